// File: doc/BRIEF.md
# Enhanced Second-Chance Victim Selector

This block picks which of N page frames to evict when a new page must be loaded. The frames form a ring with one rotating hand. Each frame holds a recently-used flag and a dirty flag. An access strobe sets the recently-used flag of a frame, and a write access also sets its dirty flag. When asked for a victim, the block walks the ring one frame per clock. It prefers frames that are both unused and clean, then unused but dirty, and it clears recently-used flags as it goes so that the search always ends.

The search runs in up to four passes of N frames each. Even passes look for an unused, clean frame and leave every flag alone. Odd passes look for an unused, dirty frame and clear the recently-used flag of every frame they step past. When a victim is found, the block reports its index and whether it was dirty in a one-cycle `done` pulse. It then clears both of the victim's flags for the incoming page and parks the hand one frame past the victim. Writing the dirty frame back and loading the new page are handled outside this block.

Top module: `evict_clock_sel`

## Requirements
- R1: After synchronous reset, `done` is low, all flags are clear and the hand points at frame 0.
- R2: An access strobe (`acc_valid`) sets the recently-used flag of frame `acc_idx` at the next clock edge. When `acc_write` is also high, it sets that frame's dirty flag as well. An access in the same cycle as a clear of the same frame wins.
- R3: A request that is high in cycle t starts a search at the hand. The j-th frame examined is looked at in cycle t+j, and `done` is high in cycle t+j+1.
- R4: In the first pass, the first frame at or after the hand with class (used=0, dirty=0) is chosen, and no flag changes.
- R5: In the second pass, the first frame with class (used=0, dirty=1) is chosen. Every frame stepped past has its recently-used flag cleared.
- R6: The third and fourth passes repeat the first and second. If the fourth pass reaches its last frame without a match, that frame is taken, so at most 4N frames are examined. With every frame (1,1), the frame at the hand is chosen after 3N+1 examinations.
- R7: `done` is a single-cycle pulse. During that pulse, `victim_idx` is the chosen frame and `victim_dirty` is its dirty flag as it was before clearing.
- R8: After a selection, the hand rests on the frame after the victim (wrapping from N-1 to 0), and the victim's two flags are clear.
- R9: A request that arrives while a search is running is ignored and yields no extra `done`.
- R10: Accesses during a search take effect at once. A frame already passed in the current pass is only looked at again in the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Frame access strobe |
| acc_idx | input | IW | Frame being accessed |
| acc_write | input | 1 | Access is a write (sets dirty flag) |
| req | input | 1 | Start a victim search (when idle) |
| done | output | 1 | One-cycle pulse: victim found |
| victim_idx | output | IW | Chosen frame |
| victim_dirty | output | 1 | Chosen frame was dirty |

## Verification
The hardest case to reach from the ports is an access that lands mid-search on a frame the hand has already aged. That frame must skip its turn in a later pass. To reach it, the bench makes every frame dirty and used, then issues a request. While the third pass is running, it re-reads the frame under the starting hand position, cycle-counted so that the access lands after the second pass cleared that frame. The victim then moves one frame on, and the latency grows by exactly one cycle. The full four-pass case is reached the same way: a ring of all-used, all-dirty frames, with a duplicate request injected mid-search.

// File: rtl/evict_pkg.sv
package evict_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic used;
        logic dirty;
    } frame_cls_t;

    localparam int NUM_PASSES = 4;

    // even pass seeks (0,0); odd pass seeks (0,1)
    function automatic logic cls_match(frame_cls_t c, logic [1:0] pass);
        return !c.used && (c.dirty == pass[0]);
    endfunction

endpackage

// File: rtl/evict_flags.sv
module evict_flags #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [IW-1:0] acc_idx,
    input  logic          acc_write,
    input  logic          age_en,
    input  logic [IW-1:0] age_idx,
    input  logic          drop_en,
    input  logic [IW-1:0] drop_idx,
    output logic [N-1:0]  used_bits,
    output logic [N-1:0]  dirty_bits
);

    for (genvar g = 0; g < N; g++) begin : g_frame
        logic hit_g, age_g, drop_g;
        assign hit_g  = acc_valid && (acc_idx == IW'(g));
        assign age_g  = age_en && (age_idx == IW'(g));
        assign drop_g = drop_en && (drop_idx == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                used_bits[g]  <= 1'b0;
                dirty_bits[g] <= 1'b0;
            end else begin
                if (hit_g)
                    used_bits[g] <= 1'b1;
                else if (age_g || drop_g)
                    used_bits[g] <= 1'b0;
                if (hit_g && acc_write)
                    dirty_bits[g] <= 1'b1;
                else if (drop_g)
                    dirty_bits[g] <= 1'b0;
            end
        end
    end

    // R2: an access marks the frame used on the following cycle
    p_acc_sets_used_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> used_bits[$past(acc_idx)]);

    // R2: a write access marks the frame dirty
    p_wr_sets_dirty_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> dirty_bits[$past(acc_idx)]);

endmodule

// File: rtl/evict_scan.sv
module evict_scan
    import evict_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [N-1:0]  used_bits,
    input  logic [N-1:0]  dirty_bits,
    output logic          age_en,
    output logic [IW-1:0] age_idx,
    output logic          drop_en,
    output logic [IW-1:0] drop_idx,
    output logic          busy,
    output logic [1:0]    pass_o,
    output logic          done,
    output logic [IW-1:0] victim_idx,
    output logic          victim_dirty
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);
    localparam logic [1:0]    FINAL_PASS = 2'(NUM_PASSES - 1);

    scan_state_e   state;
    logic [IW-1:0] hand, step, hand_nxt;
    logic [1:0]    pass;
    frame_cls_t    cur;
    logic          last_step, take;

    assign cur       = '{used: used_bits[hand], dirty: dirty_bits[hand]};
    assign last_step = (step == LAST);
    assign hand_nxt  = (hand == LAST) ? '0 : hand + 1'b1;
    assign busy      = (state == ST_SCAN);
    assign take      = busy && (cls_match(cur, pass) ||
                                (pass == FINAL_PASS && last_step));
    assign age_en    = busy && !take && pass[0];
    assign age_idx   = hand;
    assign drop_en   = take;
    assign drop_idx  = hand;
    assign pass_o    = pass;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            hand         <= '0;
            step         <= '0;
            pass         <= '0;
            done         <= 1'b0;
            victim_idx   <= '0;
            victim_dirty <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        state <= ST_SCAN;
                        step  <= '0;
                        pass  <= '0;
                    end
                end
                ST_SCAN: begin
                    hand <= hand_nxt;
                    if (take) begin
                        done         <= 1'b1;
                        victim_idx   <= hand;
                        victim_dirty <= cur.dirty;
                        state        <= ST_IDLE;
                    end else if (last_step) begin
                        step <= '0;
                        pass <= pass + 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: done never lasts two cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: hand parks one past the victim
    p_hand_after_victim_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> hand == ((victim_idx == LAST) ? '0 : victim_idx + 1'b1));

endmodule

// File: rtl/evict_clock_sel.sv
module evict_clock_sel #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [IW-1:0] acc_idx,
    input  logic          acc_write,
    input  logic          req,
    output logic          done,
    output logic [IW-1:0] victim_idx,
    output logic          victim_dirty
);

    localparam int MAX_EXAM = 4 * N;
    localparam int CW = $clog2(MAX_EXAM + 1) + 1;

    logic [N-1:0]  used_bits, dirty_bits;
    logic          age_en, drop_en, busy;
    logic [IW-1:0] age_idx, drop_idx;
    logic [1:0]    pass;

    evict_flags #(.N(N), .IW(IW)) flags_i (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_idx   (acc_idx),
        .acc_write (acc_write),
        .age_en    (age_en),
        .age_idx   (age_idx),
        .drop_en   (drop_en),
        .drop_idx  (drop_idx),
        .used_bits (used_bits),
        .dirty_bits(dirty_bits)
    );

    evict_scan #(.N(N), .IW(IW)) scan_i (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .used_bits   (used_bits),
        .dirty_bits  (dirty_bits),
        .age_en      (age_en),
        .age_idx     (age_idx),
        .drop_en     (drop_en),
        .drop_idx    (drop_idx),
        .busy        (busy),
        .pass_o      (pass),
        .done        (done),
        .victim_idx  (victim_idx),
        .victim_dirty(victim_dirty)
    );

    // examination counter used only by the bound check below
    logic [CW-1:0] exam_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) exam_cnt <= '0;
        else              exam_cnt <= exam_cnt + 1'b1;
    end

    // R6: search never exceeds four passes
    p_search_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> exam_cnt < CW'(MAX_EXAM));

    // R4: first pass leaves all flags untouched
    p_first_pass_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && pass == 2'd0 && !acc_valid) |=>
            ($stable(used_bits) && $stable(dirty_bits)));

    // R8: victim flags are clear after selection unless re-accessed
    p_victim_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(acc_valid)) |->
            (!used_bits[victim_idx] && !dirty_bits[victim_idx]));

endmodule

// File: tb/evict_clock_sel_tb.sv
module evict_clock_sel_tb_top;

    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid, acc_write, req;
    logic [IW-1:0] acc_idx;
    logic          done, victim_dirty;
    logic [IW-1:0] victim_idx;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    evict_clock_sel #(.N(N), .IW(IW)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .acc_write(acc_write), .req(req), .done(done),
        .victim_idx(victim_idx), .victim_dirty(victim_dirty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic touch(input int idx, input bit wr);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = IW'(idx); acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // issue a request, optionally inject an access or a second request
    task automatic run_req(input int exp_v, input bit exp_d, input int exp_lat,
                           input string tag, input int inj_at, input int inj_idx,
                           input int dup_at);
        int n;
        bit seen;
        n = 0; seen = 0;
        @(negedge clk);
        req = 1'b1;
        while (n < 300) begin
            @(negedge clk);
            n++;
            if (n == 1) req = 1'b0;
            if (done) begin seen = 1; break; end
            if (inj_at != 0 && n == inj_at) begin
                acc_valid = 1'b1; acc_idx = IW'(inj_idx); acc_write = 1'b0;
            end
            if (inj_at != 0 && n == inj_at + 1) acc_valid = 1'b0;
            if (dup_at != 0 && n == dup_at)     req = 1'b1;
            if (dup_at != 0 && n == dup_at + 1) req = 1'b0;
        end
        acc_valid = 1'b0; req = 1'b0;
        chk(seen && n == exp_lat, {tag, " latency R3"}, n, exp_lat);
        chk(int'(victim_idx) == exp_v, {tag, " victim"}, victim_idx, exp_v);
        chk(victim_dirty == exp_d, {tag, " dirty R7"}, victim_dirty, exp_d);
        @(negedge clk);
        chk(done == 1'b0, {tag, " single pulse R7"}, done, 0);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R1 done low after reset", done, 0);
        // all clean, hand at 0: frame 0 at first look
        run_req(0, 0, 2, "R1 R4 clean ring", 0, 0, 0);
    endtask

    task automatic t_first_pass;
        touch(1, 1); touch(2, 1); touch(3, 0);
        // hand 1: frames 1,2 (1,1), 3 (1,0), 4 clean
        run_req(4, 0, 5, "R2 R4 skip used", 0, 0, 0);
    endtask

    task automatic t_all_dirty;
        for (int i = 0; i < N; i++) touch(i, 1);
        // hand 5; 3N+1 examinations; duplicate req mid-search
        run_req(5, 1, 3 * N + 2, "R5 R6 R9 all used+dirty", 0, 0, 10);
        repeat (4) begin
            @(negedge clk);
            chk(done == 1'b0, "R9 no extra done", done, 0);
        end
    endtask

    task automatic t_second_pass;
        touch(5, 0); touch(6, 0);
        // hand 6: pass 1 nothing, pass 2 ages 6 and takes 7
        run_req(7, 1, N + 3, "R5 unused dirty", 0, 0, 0);
    endtask

    task automatic t_victim_reset;
        // hand 8: frame 7 was just cleared, found at end of pass 1
        run_req(7, 0, N + 1, "R8 victim cleared and hand wrap", 0, 0, 0);
    endtask

    task automatic t_mid_access;
        for (int i = 0; i < N; i++) touch(i, 1);
        // hand 8; frame 8 re-read during pass 3 after being aged in pass 2
        run_req(9, 1, 3 * N + 3, "R10 access during search", 40, 8, 0);
    endtask

    initial begin
        rst = 1'b1; req = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_pass();
        t_all_dirty();
        t_second_pass();
        t_victim_reset();
        t_mid_access();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule